// File: doc/BRIEF.md
# Ring Producer with Pass-Count Stamping

This block is the write side of a circular descriptor ring. Each entry offered on the input stream is stored at the current head slot of an internal ring memory. The head then moves forward, and after the last slot it returns to slot 0. Before the last 32-bit word of an entry is stored, the block writes two things into its upper bits: a configured 8-bit ring identifier and a 4-bit pass counter.

The pass counter advances once for each trip the producer makes around the ring. Its least significant bit therefore flips between one trip and the next. A consumer walking the ring can find where fresh entries stop by reading that bit from each entry, and it never needs to read the head pointer. The consumer returns slots by writing its tail index. The block asserts full, and withholds ready, whenever one more write would make the head catch up with the tail. A one-cycle interrupt pulse follows every stored entry. A combinational read port exposes any slot to a checker.

Top module: `ring_producer`

## Requirements
- R1: While reset is held and after release: head_o = 0, full_o = 0, irq_o = 0, in_ready_o = 1, and every slot reads back as all zeros, so its pass count is 0.
- R2: An entry is accepted when in_valid_i and in_ready_o are both high on a rising edge. It is stored at slot head_o. head_o then advances by one, going from DEPTH-1 back to 0.
- R3: Word k of an entry occupies bits [32k+31:32k], and the last word is k = WORDS-1. Bits [31:28] of the last word hold the pass count. Every entry written on the first trip around the ring, starting at slot 0, is stamped with count 1.
- R4: The pass count increments, modulo 16, on each accepted write into slot 0, and that entry carries the new value. Count 15 is followed by 0 and then by 1.
- R5: Bits [27:20] of the stored last word equal ring_id_i as sampled at the accepting edge.
- R6: All other bits of the entry (every word below the last, and bits [19:0] of the last word) are stored exactly as presented.
- R7: full_o is high, and in_ready_o low, exactly when (head_o+1) mod DEPTH equals the tail index. An entry offered while full is dropped: head_o and every slot stay unchanged. Fullness in a cycle uses the tail index held before that cycle's tail update.
- R8: On a rising edge with tail_we_i high, the tail index takes tail_i if tail_i < DEPTH. A value of DEPTH or above is ignored.
- R9: irq_o is high for exactly the one cycle after each accepted entry and is low otherwise.
- R10: rd_data_o shows, in the same cycle, the contents of slot rd_idx_i. It reads as zero when rd_idx_i >= DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ring_id_i | input | 8 | Identifier stamped into every entry |
| in_valid_i | input | 1 | Entry offered |
| in_data_i | input | 32*WORDS | Entry payload, word 0 in the low bits |
| in_ready_o | output | 1 | Entry will be accepted (ring not full) |
| tail_we_i | input | 1 | Consumer tail index update strobe |
| tail_i | input | IDX_W | New consumer tail index |
| rd_idx_i | input | IDX_W | Slot to read back |
| rd_data_o | output | 32*WORDS | Contents of the selected slot |
| head_o | output | IDX_W | Next slot to be written |
| full_o | output | 1 | One free slot is left, so no write is allowed |
| irq_o | output | 1 | Pulse after each stored entry |

## Verification
The overlap that matters is an entry push landing in the same cycle as a tail update, most sharply while the ring is full. Fullness must then be judged against the old tail, so the push is refused and only becomes possible on the next cycle. The bench builds this case directly: it fills the ring, then offers an entry while it moves the tail. Under random stimulus it issues legal tail advances on about 40% of cycles, alongside a push rate of about 70%. The bench's reference model applies the push decision before the tail update, and the head, full flag, interrupt and stored stamps are compared against it after every edge.

// File: rtl/ring_prod_pkg.sv
package ring_prod_pkg;
  localparam int WORD_W  = 32;
  localparam int CNT_W   = 4;
  localparam int ID_W    = 8;
  localparam int CNT_LSB = 28;
  localparam int ID_LSB  = 20;
  localparam int KEEP_W  = ID_LSB;
endpackage

// File: rtl/ring_ptr_ctrl.sv
module ring_ptr_ctrl
  import ring_prod_pkg::*;
#(
  parameter int DEPTH = 12,
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             tail_we_i,
  input  logic [IDX_W-1:0] tail_i,
  output logic             ready_o,
  output logic             full_o,
  output logic             wr_en_o,
  output logic             irq_o,
  output logic [IDX_W-1:0] head_o,
  output logic [CNT_W-1:0] stamp_cnt_o
);
  localparam logic [IDX_W-1:0] LAST    = IDX_W'(DEPTH - 1);
  localparam logic [IDX_W:0]   DEPTH_X = (IDX_W + 1)'(DEPTH);

  logic [IDX_W-1:0] head_q, tail_q, head_nxt;
  logic [CNT_W-1:0] cnt_q;
  logic             irq_q, at_base, full, wr_en;

  always_comb begin
    head_nxt = (head_q == LAST) ? '0 : head_q + 1'b1;
    full     = (head_nxt == tail_q);
    wr_en    = push_i && !full;
    at_base  = (head_q == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= wr_en;
      if (wr_en) begin
        head_q <= head_nxt;
        if (at_base) cnt_q <= cnt_q + 1'b1;
      end
      if (tail_we_i && ({1'b0, tail_i} < DEPTH_X)) tail_q <= tail_i;
    end
  end

  assign ready_o     = !full;
  assign full_o      = full;
  assign wr_en_o     = wr_en;
  assign irq_o       = irq_q;
  assign head_o      = head_q;
  assign stamp_cnt_o = at_base ? cnt_q + 1'b1 : cnt_q;

  assert_cnt_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && at_base) |=> (cnt_q == $past(cnt_q) + 1'b1));
  assert_cnt_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(wr_en && at_base)) |=> $stable(cnt_q));
  assert_no_overrun_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && !tail_we_i) |=> (head_q != tail_q));
  assert_tail_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, tail_q} < DEPTH_X));
  assert_head_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, head_q} < DEPTH_X));
endmodule

// File: rtl/ring_stamp.sv
module ring_stamp
  import ring_prod_pkg::*;
#(
  parameter int WORDS = 2
) (
  input  logic [WORDS*WORD_W-1:0] entry_i,
  input  logic [CNT_W-1:0]        cnt_i,
  input  logic [ID_W-1:0]         id_i,
  output logic [WORDS*WORD_W-1:0] entry_o
);
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    if (w == WORDS - 1) begin : g_last
      assign entry_o[w*WORD_W +: WORD_W] = {cnt_i, id_i, entry_i[w*WORD_W +: KEEP_W]};
    end else begin : g_pass
      assign entry_o[w*WORD_W +: WORD_W] = entry_i[w*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/ring_store.sv
module ring_store
  import ring_prod_pkg::*;
#(
  parameter int DEPTH   = 12,
  parameter int IDX_W   = 4,
  parameter int ENTRY_W = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [IDX_W-1:0]   widx_i,
  input  logic [ENTRY_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]   ridx_i,
  output logic [ENTRY_W-1:0] rdata_o
);
  localparam logic [IDX_W:0] DEPTH_X = (IDX_W + 1)'(DEPTH);

  logic [ENTRY_W-1:0] mem_q [DEPTH];

  // Cleared at reset so never-written slots carry pass count 0.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[widx_i] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if ({1'b0, ridx_i} < DEPTH_X) rdata_o = mem_q[ridx_i];
  end
endmodule

// File: rtl/ring_producer.sv
module ring_producer
  import ring_prod_pkg::*;
#(
  parameter int  DEPTH   = 12,
  parameter int  WORDS   = 2,
  localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int ENTRY_W = WORDS * WORD_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ID_W-1:0]    ring_id_i,
  input  logic               in_valid_i,
  input  logic [ENTRY_W-1:0] in_data_i,
  output logic               in_ready_o,
  input  logic               tail_we_i,
  input  logic [IDX_W-1:0]   tail_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic [ENTRY_W-1:0] rd_data_o,
  output logic [IDX_W-1:0]   head_o,
  output logic               full_o,
  output logic               irq_o
);
  logic               wr_en;
  logic [CNT_W-1:0]   stamp_cnt;
  logic [ENTRY_W-1:0] stamped;

  ring_ptr_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (in_valid_i),
    .tail_we_i   (tail_we_i),
    .tail_i      (tail_i),
    .ready_o     (in_ready_o),
    .full_o      (full_o),
    .wr_en_o     (wr_en),
    .irq_o       (irq_o),
    .head_o      (head_o),
    .stamp_cnt_o (stamp_cnt)
  );

  ring_stamp #(.WORDS(WORDS)) u_stamp (
    .entry_i (in_data_i),
    .cnt_i   (stamp_cnt),
    .id_i    (ring_id_i),
    .entry_o (stamped)
  );

  ring_store #(.DEPTH(DEPTH), .IDX_W(IDX_W), .ENTRY_W(ENTRY_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en),
    .widx_i  (head_o),
    .wdata_i (stamped),
    .ridx_i  (rd_idx_i),
    .rdata_o (rd_data_o)
  );

  assert_irq_follows_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(in_valid_i && in_ready_o));
  assert_stall_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_valid_i && in_ready_o) |=> $stable(head_o));
endmodule

// File: tb/ring_producer_test.sv
module ring_producer_test;
  localparam int DEPTH = 12;
  localparam int IW    = 4;
  localparam int EW    = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    ring_id = 8'h00;
  logic          in_valid = 1'b0;
  logic [EW-1:0] in_data = '0;
  logic          in_ready;
  logic          tail_we = 1'b0;
  logic [IW-1:0] tail = '0;
  logic [IW-1:0] rd_idx = '0;
  logic [EW-1:0] rd_data;
  logic [IW-1:0] head;
  logic          full, irq;

  always #5 clk = ~clk;

  ring_producer uut (
    .clk_i(clk), .rst_ni(rst_n), .ring_id_i(ring_id),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_ready_o(in_ready),
    .tail_we_i(tail_we), .tail_i(tail), .rd_idx_i(rd_idx), .rd_data_o(rd_data),
    .head_o(head), .full_o(full), .irq_o(irq)
  );

  int total = 0, bad = 0;
  bit done = 0, rollover_seen = 0;
  logic [EW-1:0] m_mem [DEPTH];
  int m_head = 0, m_tail = 0;
  logic [3:0] m_cnt = 4'd0;

  task automatic chk(input bit ok, input string req, input logic [EW-1:0] act, input logic [EW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int nxt(input int i);
    return (i == DEPTH - 1) ? 0 : i + 1;
  endfunction

  function automatic bit m_full();
    return nxt(m_head) == m_tail;
  endfunction

  function automatic logic [EW-1:0] stamp(input logic [EW-1:0] d, input logic [3:0] c, input logic [7:0] id);
    logic [EW-1:0] r = d;
    r[63:60] = c;
    r[59:52] = id;
    return r;
  endfunction

  task automatic chk_read(input int idx);
    logic [EW-1:0] e;
    rd_idx = IW'(idx);
    #1;
    e = (idx < DEPTH) ? m_mem[idx] : '0;
    if (idx >= DEPTH) chk(rd_data == '0, "R10 out-of-range read", rd_data, '0);
    chk(rd_data[63:60] == e[63:60], "R3/R4 pass count", EW'(rd_data[63:60]), EW'(e[63:60]));
    chk(rd_data[59:52] == e[59:52], "R5 ring id", EW'(rd_data[59:52]), EW'(e[59:52]));
    chk(rd_data[51:0] == e[51:0], "R6 payload", EW'(rd_data[51:0]), EW'(e[51:0]));
  endtask

  // Called at a negedge; returns at the following negedge after checks.
  task automatic cyc(input bit v, input logic [EW-1:0] d, input bit twe, input int t, input int ridx);
    bit acc;
    logic [3:0] c;
    in_valid = v; in_data = d; tail_we = twe; tail = IW'(t);
    #1;
    chk(in_ready == !m_full(), "R7 ready", EW'(in_ready), EW'(!m_full()));
    acc = v && !m_full();
    @(posedge clk);
    if (acc) begin
      c = m_cnt;
      if (m_head == 0) begin
        c = c + 4'd1;
        if (c == 4'd0) rollover_seen = 1;
      end
      m_cnt = c;
      m_mem[m_head] = stamp(d, c, ring_id);
      m_head = nxt(m_head);
    end
    if (twe && t < DEPTH) m_tail = t;
    @(negedge clk);
    in_valid = 1'b0; tail_we = 1'b0;
    chk(head == IW'(m_head), "R2 head", EW'(head), EW'(m_head));
    chk(full == m_full(), "R7/R8 full", EW'(full), EW'(m_full()));
    chk(irq == acc, "R9 irq", EW'(irq), EW'(acc));
    chk_read(ridx);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(head == '0, "R1 head", EW'(head), 0);
    chk(full == 1'b0, "R1 full", EW'(full), 0);
    chk(irq == 1'b0, "R1 irq", EW'(irq), 0);
    chk(in_ready == 1'b1, "R1 ready", EW'(in_ready), 1);
    for (int i = 0; i < 16; i++) chk_read(i);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 16; i++) chk_read(i);

    // R2/R3: fill first pass with tail at 0
    ring_id = 8'hA5;
    for (int i = 0; i < DEPTH - 1; i++)
      cyc(1, {$urandom, $urandom}, 0, 0, i);
    chk(full == 1'b1, "R7 full after fill", EW'(full), 1);
    for (int i = 0; i < DEPTH - 1; i++) begin
      rd_idx = IW'(i); #1;
      chk(rd_data[63:60] == 4'd1, "R3 first pass count", EW'(rd_data[63:60]), 1);
    end
    // R7: push while full is dropped
    cyc(1, 64'hDEAD_BEEF_0BAD_F00D, 0, 0, DEPTH - 1);
    chk(rd_data == '0, "R7 dropped entry", rd_data, '0);
    // R8: out-of-range tail ignored
    cyc(0, '0, 1, 13, 0);
    chk(full == 1'b1, "R8 bad tail ignored", EW'(full), 1);
    // push and tail move in the same cycle: old tail decides
    cyc(1, 64'h1111_2222_3333_4444, 1, 5, DEPTH - 1);
    chk(head == IW'(DEPTH - 1), "R7 same-cycle push refused", EW'(head), DEPTH - 1);
    cyc(1, 64'h5555_6666_7777_8888, 0, 0, DEPTH - 1);
    cyc(1, 64'h9999_AAAA_BBBB_CCCC, 0, 0, 0);
    rd_idx = 4'd0; #1;
    chk(rd_data[63:60] == 4'd2, "R4 second pass count", EW'(rd_data[63:60]), 2);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      bit v, twe;
      int t, occ;
      v = ($urandom_range(0, 9) < 7);
      twe = ($urandom_range(0, 9) < 4);
      if ($urandom_range(0, 19) == 0) t = 12 + $urandom_range(0, 3);
      else begin
        occ = (m_head - m_tail + DEPTH) % DEPTH;
        t = (m_tail + $urandom_range(0, occ)) % DEPTH;
      end
      if ($urandom_range(0, 31) == 0) ring_id = 8'($urandom);
      cyc(v, {$urandom, $urandom}, twe, t, $urandom_range(0, 15));
    end
    chk(rollover_seen, "R4 rollover 15->0 exercised", EW'(rollover_seen), 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule